// File: doc/BRIEF.md
# One-Place Broadcast Event Channel

The block carries events from a single producer to a set of consumers that run on their own schedule. It keeps exactly one stored payload and, for every consumer, a pending flag. When the producer emits, the payload is replaced and every consumer's pending flag is raised. The producer never waits, so a consumer that has not yet taken the previous event loses it to the new one.

Each consumer also holds a frozen copy of its pending flag. A start strobe from the consumer loads that copy at the beginning of a reaction. For the rest of the reaction the consumer decides from the frozen copy only, so an emit that arrives mid-reaction cannot change what the reaction sees. When the consumer takes the event, it pulses its consume line and reads the payload in the same cycle. That pulse clears both of its flags.

An overrun output pulses whenever an emit arrives while some consumer still has an event pending. Widths and the consumer count are parameters. Reset is synchronous and active high.

Top module: `event_bcast_chan`

## Requirements
- R1: While `rst` is high at a clock edge, every pending flag, every frozen flag and the stored payload are zero after that edge.
- R2: An emit (`emit_i` high at an edge) sets the pending flag of every receiver after that edge, whatever their earlier state.
- R3: An emit replaces the stored payload with `emit_data_i` after that edge. Without an emit, `value_o` holds its value, so only one payload is ever kept.
- R4: A consume pulse on bit i of `rx_consume_i` without an emit clears pending bit i after the edge. The pending bits of the other receivers are unchanged.
- R5: If an emit and a consume for receiver i fall in the same cycle, pending bit i is set after the edge, so the new event is kept.
- R6: A start pulse on bit i of `rx_start_i` loads frozen bit i with pending bit i as it stood before that edge. An emit in the same cycle is not seen by the new snapshot.
- R7: Without a start for receiver i, frozen bit i is changed by nothing except a consume for receiver i, which clears it. In particular, an emit leaves it as it was.
- R8: `overrun_o` is high, combinationally, in exactly the cycles where `emit_i` is high and at least one pending flag is set.
- R9: When start and consume for receiver i fall in the same cycle, the snapshot load takes priority for frozen bit i, while pending bit i is cleared (unless an emit also occurs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| emit_i | input | 1 | Producer emit strobe |
| emit_data_i | input | DATA_W | Payload carried with the emit |
| rx_start_i | input | NUM_RX | Per-receiver start-of-reaction strobe |
| rx_consume_i | input | NUM_RX | Per-receiver consume strobe |
| rx_flag_o | output | NUM_RX | Per-receiver pending (active) flag |
| rx_snap_o | output | NUM_RX | Per-receiver frozen flag used during a reaction |
| value_o | output | DATA_W | Stored payload |
| overrun_o | output | 1 | Emit while some event is still pending |

## Verification
The bound checker watches, on every cycle, that an emit raises all pending flags and loads the payload, and that the payload holds when there is no emit. It also checks that a consume clears only its own pending flag, that a start copies the pre-edge pending flag, and that frozen flags ignore emits. Some effects show only across cycles of a scenario. These include an event surviving a same-cycle consume, and a reaction started in the same cycle as an emit seeing no event. They also include the loss of an unconsumed event to the next emit, start and consume together, and reset in mid-run. The bench's reference model tracks these across directed and pseudo-random sequences and compares every output on every cycle.

// File: rtl/evch_pkg.sv
package evch_pkg;

  // Next pending flag: an emit always wins over a consume.
  function automatic logic pend_next(input logic emit, input logic consume,
                                     input logic cur);
    if (emit)         return 1'b1;
    else if (consume) return 1'b0;
    else              return cur;
  endfunction

  // Next frozen flag: a start snapshots the pre-edge pending flag,
  // a consume alone retires the snapshot, otherwise it holds.
  function automatic logic snap_next(input logic start, input logic consume,
                                     input logic pend, input logic cur);
    if (start)        return pend;
    else if (consume) return 1'b0;
    else              return cur;
  endfunction

endpackage

// File: rtl/evch_rx_cell.sv
module evch_rx_cell
  import evch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic emit,
  input  logic start,
  input  logic consume,
  output logic pend_o,
  output logic snap_o
);

  logic pend_q;
  logic snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      pend_q <= pend_next(emit, consume, pend_q);
      snap_q <= snap_next(start, consume, pend_q, snap_q);
    end
  end

  assign pend_o = pend_q;
  assign snap_o = snap_q;

endmodule

// File: rtl/evch_value_store.sv
module evch_value_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst)       val_q <= '0;
    else if (load) val_q <= din;
  end

  assign dout = val_q;

endmodule

// File: rtl/evch_overrun.sv
module evch_overrun #(
  parameter int NUM_RX = 4
) (
  input  logic              emit,
  input  logic [NUM_RX-1:0] pend,
  output logic              overrun
);

  logic any_pending;

  always_comb begin
    any_pending = 1'b0;
    for (int k = 0; k < NUM_RX; k++) any_pending = any_pending | pend[k];
  end

  assign overrun = emit & any_pending;

endmodule

// File: rtl/event_bcast_chan.sv
module event_bcast_chan #(
  parameter int NUM_RX = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit_i,
  input  logic [DATA_W-1:0] emit_data_i,
  input  logic [NUM_RX-1:0] rx_start_i,
  input  logic [NUM_RX-1:0] rx_consume_i,
  output logic [NUM_RX-1:0] rx_flag_o,
  output logic [NUM_RX-1:0] rx_snap_o,
  output logic [DATA_W-1:0] value_o,
  output logic              overrun_o
);

  logic [NUM_RX-1:0] pend_w;
  logic [NUM_RX-1:0] snap_w;

  for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
    evch_rx_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .emit    (emit_i),
      .start   (rx_start_i[g]),
      .consume (rx_consume_i[g]),
      .pend_o  (pend_w[g]),
      .snap_o  (snap_w[g])
    );
  end

  evch_value_store #(.DATA_W(DATA_W)) u_value (
    .clk  (clk),
    .rst  (rst),
    .load (emit_i),
    .din  (emit_data_i),
    .dout (value_o)
  );

  evch_overrun #(.NUM_RX(NUM_RX)) u_ovr (
    .emit    (emit_i),
    .pend    (pend_w),
    .overrun (overrun_o)
  );

  assign rx_flag_o = pend_w;
  assign rx_snap_o = snap_w;

endmodule

// File: rtl/evch_checker.sv
module evch_checker #(
  parameter int NUM_RX = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              emit_i,
  input logic [DATA_W-1:0] emit_data_i,
  input logic [NUM_RX-1:0] rx_start_i,
  input logic [NUM_RX-1:0] rx_consume_i,
  input logic [NUM_RX-1:0] rx_flag_o,
  input logic [NUM_RX-1:0] rx_snap_o,
  input logic [DATA_W-1:0] value_o,
  input logic              overrun_o
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rx_flag_o == '0 && rx_snap_o == '0 && value_o == '0)); // R1

  AST_EMIT_RAISES_ALL: assert property (@(posedge clk) disable iff (rst)
    emit_i |=> (rx_flag_o == '1)); // R2

  AST_EMIT_LOADS_VALUE: assert property (@(posedge clk) disable iff (rst)
    emit_i |=> (value_o == $past(emit_data_i))); // R3

  AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !emit_i |=> $stable(value_o)); // R3

  AST_CONSUME_CLEARS_OWN: assert property (@(posedge clk) disable iff (rst)
    !emit_i |=> ((rx_flag_o & $past(rx_consume_i)) == '0)); // R4

  AST_OTHERS_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    !emit_i |=> (((rx_flag_o ^ $past(rx_flag_o)) & ~$past(rx_consume_i)) == '0)); // R4

  AST_EMIT_BEATS_CONSUME: assert property (@(posedge clk) disable iff (rst)
    (emit_i && rx_consume_i != '0) |=> (rx_flag_o == '1)); // R5

  AST_SNAP_FROM_PRE_EDGE: assert property (@(posedge clk) disable iff (rst)
    (rx_start_i != '0) |=>
      (((rx_snap_o ^ $past(rx_flag_o)) & $past(rx_start_i)) == '0)); // R6

  AST_SNAP_IGNORES_EMIT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((rx_snap_o ^ $past(rx_snap_o)) &
               ~($past(rx_start_i) | $past(rx_consume_i))) == '0)); // R7

  AST_NO_SPURIOUS_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    !emit_i |-> !overrun_o); // R8

  AST_OVERRUN_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (rx_flag_o == '0) |-> !overrun_o); // R8

endmodule

bind event_bcast_chan evch_checker #(.NUM_RX(NUM_RX), .DATA_W(DATA_W)) u_evch_chk (
  .clk          (clk),
  .rst          (rst),
  .emit_i       (emit_i),
  .emit_data_i  (emit_data_i),
  .rx_start_i   (rx_start_i),
  .rx_consume_i (rx_consume_i),
  .rx_flag_o    (rx_flag_o),
  .rx_snap_o    (rx_snap_o),
  .value_o      (value_o),
  .overrun_o    (overrun_o)
);

// File: tb/test_event_bcast_chan.sv
module test_event_bcast_chan;

  localparam int CLK_PERIOD = 10;
  localparam int NRX = 4;
  localparam int DW  = 8;
  localparam int WATCHDOG_CYCLES = 5000;

  logic          clk = 1'b0;
  logic          rst;
  logic          emit_i;
  logic [DW-1:0] emit_data_i;
  logic [NRX-1:0] rx_start_i;
  logic [NRX-1:0] rx_consume_i;
  logic [NRX-1:0] rx_flag_o;
  logic [NRX-1:0] rx_snap_o;
  logic [DW-1:0]  value_o;
  logic           overrun_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference state
  bit model_pend [NRX];
  bit model_snap [NRX];
  int model_value;

  always #(CLK_PERIOD/2) clk = ~clk;

  event_bcast_chan #(.NUM_RX(NRX), .DATA_W(DW)) i_event_bcast_chan (
    .clk          (clk),
    .rst          (rst),
    .emit_i       (emit_i),
    .emit_data_i  (emit_data_i),
    .rx_start_i   (rx_start_i),
    .rx_consume_i (rx_consume_i),
    .rx_flag_o    (rx_flag_o),
    .rx_snap_o    (rx_snap_o),
    .value_o      (value_o),
    .overrun_o    (overrun_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int pack_bits(input bit b [NRX]);
    int v = 0;
    for (int k = 0; k < NRX; k++) if (b[k]) v += (1 << k);
    return v;
  endfunction

  // One clock: drive inputs, compare outputs before the edge, advance the model.
  task automatic cycle(input bit e, input int d, input int st, input int co,
                       input string tag);
    int exp_pend;
    int exp_snap;
    bit any;
    bit nxt_pend [NRX];
    emit_i       = e;
    emit_data_i  = DW'(d);
    rx_start_i   = NRX'(st);
    rx_consume_i = NRX'(co);
    #(CLK_PERIOD/4);
    exp_pend = pack_bits(model_pend);
    exp_snap = pack_bits(model_snap);
    any = 0;
    foreach (model_pend[k]) if (model_pend[k]) any = 1;
    check(int'(rx_flag_o) == exp_pend, tag, "pending flags", int'(rx_flag_o), exp_pend);
    check(int'(rx_snap_o) == exp_snap, tag, "frozen flags", int'(rx_snap_o), exp_snap);
    check(int'(value_o) == model_value, tag, "payload", int'(value_o), model_value);
    if (!rst)
      check(overrun_o == (e && any), tag, "overrun (R8)", int'(overrun_o), int'(e && any));
    @(posedge clk);
    if (rst) begin
      foreach (model_pend[k]) begin model_pend[k] = 0; model_snap[k] = 0; end
      model_value = 0;
    end else begin
      for (int k = 0; k < NRX; k++) begin
        bit s_k = ((st >> k) & 1) != 0;
        bit c_k = ((co >> k) & 1) != 0;
        // receiver view: snapshot sees what was pending before this edge
        if (s_k)      model_snap[k] = model_pend[k];
        else if (c_k) model_snap[k] = 0;
        nxt_pend[k] = e ? 1'b1 : (c_k ? 1'b0 : model_pend[k]);
      end
      foreach (model_pend[k]) model_pend[k] = nxt_pend[k];
      if (e) model_value = d & ((1 << DW) - 1);
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    foreach (model_pend[k]) begin model_pend[k] = 0; model_snap[k] = 0; end
    model_value = 0;
    rst = 1'b1;
    emit_i = 0; emit_data_i = '0; rx_start_i = '0; rx_consume_i = '0;
    @(negedge clk);
    // R1: reset state (first cycle only establishes the model)
    cycle(0, 0, 0, 0, "R1");
    cycle(1, 8'h33, 4'hF, 4'hF, "R1");
    rst = 1'b0;
    cycle(0, 0, 0, 0, "R1");

    // R2: emit raises every receiver; no overrun from empty state (R8)
    cycle(1, 8'hA5, 0, 0, "R2");
    cycle(0, 0, 0, 0, "R2");
    // R6: receiver 0 starts a reaction and sees the event
    cycle(0, 0, 4'b0001, 0, "R6");
    // R4: receiver 1 consumes, others keep their flags
    cycle(0, 0, 0, 4'b0010, "R4");
    // R6: receiver 1 starts in the same cycle as a new emit: snapshot stays 0
    cycle(1, 8'h5A, 4'b0010, 0, "R6");
    cycle(0, 0, 0, 0, "R6");
    // R7: emit while receiver 0 and 1 snapshots held
    cycle(1, 8'h11, 0, 0, "R7");
    cycle(0, 0, 0, 0, "R7");
    // R5: emit and consume of receiver 2 together keep the flag
    cycle(1, 8'h22, 0, 4'b0100, "R5");
    cycle(0, 0, 0, 0, "R5");
    // R3: back-to-back emits, only the last payload kept
    cycle(1, 8'h01, 0, 0, "R3");
    cycle(1, 8'h02, 0, 0, "R3");
    cycle(0, 0, 0, 0, "R3");
    // R9: start and consume together on receiver 3
    cycle(0, 0, 4'b1000, 4'b1000, "R9");
    cycle(0, 0, 0, 0, "R9");
    // R8: drain all, then emit with nothing pending
    cycle(0, 0, 4'hF, 4'hF, "R8");
    cycle(0, 0, 0, 4'hF, "R8");
    cycle(1, 8'h77, 0, 0, "R8");
    cycle(1, 8'h78, 0, 0, "R8");

    // pseudo-random traffic across all behaviours
    for (int n = 0; n < 400; n++) begin
      bit e = ($urandom_range(0, 3) == 0);
      cycle(e, $urandom_range(0, 255), $urandom_range(0, 15) & $urandom_range(0, 15),
            $urandom_range(0, 15) & $urandom_range(0, 15), "R2,R3,R4,R5,R6,R7,R9");
    end

    // R1: reset in mid-run
    cycle(1, 8'hEE, 0, 0, "R1");
    cycle(0, 0, 4'hF, 0, "R1");
    rst = 1'b1;
    cycle(0, 0, 0, 0, "R1");
    rst = 1'b0;
    cycle(0, 0, 0, 0, "R1");
    cycle(0, 0, 0, 0, "R1");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule